// File: doc/BRIEF.md
# GPIO Interrupt Sense Unit

This block sits behind a bank of general-purpose pins and turns pin activity into interrupt status. Each pin passes through its own synchronizer chain. Every pin also has its own settings. An interrupt-mode bit decides whether the pin takes part in sensing at all. An invert bit picks the active polarity. An edge-select bit chooses between level and edge sensing. A both-edge bit makes either transition count. Level status follows the synchronized pin. Edge status is held in a latch until software writes a one to that pin's position in the clear vector.

The status vector is combined with a per-pin enable to form a single interrupt request. A build-time parameter can remove both-edge capture. In that variant the both-edge settings have no effect. Register decoding, glitch filtering and wake-up handling belong to the surrounding logic.

Top module: `gpio_irq_sense`

## Requirements
- R1: After reset, with all configuration inputs at 0, every status bit and the interrupt request are 0.
- R2: A change on a pin reaches the sensing logic through a two-flop synchronizer. A level-mode status bit reflects a pin driven before clock edge k once edge k+1 has passed. An edge-mode status bit is set once edge k+2 has passed.
- R3: A pin whose interrupt-mode bit (`cfg_irq_mode`) is 0 always shows status 0, whatever its pin level or latch history.
- R4: In level mode (`cfg_edge`=0) the status bit equals the synchronized pin XOR `cfg_invert`. `cfg_invert`=0 means active high and 1 means active low. Writing the clear vector does not change it.
- R5: In edge mode (`cfg_edge`=1, `cfg_both`=0), `cfg_invert`=0 latches a rising edge and `cfg_invert`=1 latches a falling edge. The opposite edge is ignored. A latched bit stays set after the pin returns.
- R6: With both-edge support built in (`HAS_BOTH`=1), a pin in edge mode with `cfg_both`=1 latches rising and falling edges alike, whatever its invert bit.
- R7: With `HAS_BOTH`=0, the `cfg_both` input has no effect on status, including on config-change detection.
- R8: A 1 at bit i of `clr_vec` in a cycle clears pin i's edge latch at the next clock edge. A 0 bit leaves that latch unchanged.
- R9: When a detected edge and a clear reach the same pin in the same cycle, the latch ends up set.
- R10: No edge is recorded in a cycle where that pin's configuration differs from the previous cycle. Leaving edge mode or interrupt mode empties the pin's latch.
- R11: `irq` is 1 exactly when some bit of status AND `irq_enable` is 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pin_in | input | NPIN | Raw asynchronous pin levels |
| cfg_irq_mode | input | NPIN | 1 = pin takes part in interrupt sensing |
| cfg_invert | input | NPIN | 1 = active low / falling edge |
| cfg_edge | input | NPIN | 1 = edge sensing, 0 = level sensing |
| cfg_both | input | NPIN | 1 = both edges latch (when built in) |
| irq_enable | input | NPIN | Per-pin enable into the request |
| clr_vec | input | NPIN | Write-one-to-clear for edge latches |
| status | output | NPIN | Per-pin interrupt status |
| irq | output | 1 | Combined interrupt request |

## Verification
The bench builds two copies side by side from the same stimulus. The first is the full 32-pin bank with both-edge capture and a two-stage synchronizer. The second is an 8-pin bank with `HAS_BOTH`=0. The first copy reaches every pin position and the both-edge path. The second shows, in the same cycles, that the same both-edge settings do nothing. Mixed random configuration changes bring config-change suppression and clear/edge collisions within reach on many pins at once.

// File: rtl/gis_pkg.sv
package gis_pkg;

    typedef struct packed {
        logic both;
        logic edge_sel;
        logic invert;
        logic irq_mode;
    } pin_cfg_t;

    localparam int CFG_BITS = $bits(pin_cfg_t);

    // Edge event for one pin: raw transition compare, polarity picks the
    // direction, and a configuration change in this cycle suppresses it.
    function automatic logic edge_event(input pin_cfg_t cfg_now,
                                        input pin_cfg_t cfg_was,
                                        input logic     cur,
                                        input logic     prv);
        logic rise;
        logic fall;
        logic sel;
        rise = cur & ~prv;
        fall = ~cur & prv;
        if (cfg_now.both) sel = rise | fall;
        else              sel = cfg_now.invert ? fall : rise;
        return cfg_now.irq_mode & cfg_now.edge_sel & (cfg_now == cfg_was) & sel;
    endfunction

endpackage

// File: rtl/gis_sync.sv
module gis_sync #(
    parameter int W      = 32,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d_in,
    output logic [W-1:0] d_out
);
    localparam int LAST = STAGES - 1;

    typedef struct packed {
        logic [STAGES-1:0][W-1:0] chain;
    } sync_t;

    sync_t s_d, s_q;

    always_comb begin
        s_d          = s_q;
        s_d.chain[0] = d_in;
        for (int k = 1; k < STAGES; k++) begin
            s_d.chain[k] = s_q.chain[k-1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign d_out = s_q.chain[LAST];

endmodule

// File: rtl/gis_sense.sv
module gis_sense
    import gis_pkg::*;
#(
    parameter int NPIN     = 32,
    parameter bit HAS_BOTH = 1'b1
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NPIN-1:0] pin_s,
    input  logic [NPIN-1:0] cfg_irq_mode,
    input  logic [NPIN-1:0] cfg_invert,
    input  logic [NPIN-1:0] cfg_edge,
    input  logic [NPIN-1:0] cfg_both,
    input  logic [NPIN-1:0] clr_vec,
    output logic [NPIN-1:0] status
);
    localparam logic BOTH_OK = HAS_BOTH;

    typedef struct packed {
        pin_cfg_t [NPIN-1:0] cfg;
        logic     [NPIN-1:0] prev;
        logic     [NPIN-1:0] lat;
    } sense_t;

    sense_t              s_d, s_q;
    pin_cfg_t [NPIN-1:0] cfg_now;
    logic     [NPIN-1:0] hit;

    for (genvar i = 0; i < NPIN; i++) begin : g_pin
        assign cfg_now[i] = '{both:     cfg_both[i] & BOTH_OK,
                              edge_sel: cfg_edge[i],
                              invert:   cfg_invert[i],
                              irq_mode: cfg_irq_mode[i]};
        assign hit[i] = edge_event(cfg_now[i], s_q.cfg[i], pin_s[i], s_q.prev[i]);
    end

    always_comb begin
        s_d      = s_q;
        s_d.cfg  = cfg_now;
        s_d.prev = pin_s;
        for (int i = 0; i < NPIN; i++) begin
            if (cfg_now[i].irq_mode && cfg_now[i].edge_sel)
                s_d.lat[i] = (s_q.lat[i] & ~clr_vec[i]) | hit[i];
            else
                s_d.lat[i] = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    always_comb begin
        for (int i = 0; i < NPIN; i++) begin
            if (!cfg_now[i].irq_mode)    status[i] = 1'b0;
            else if (cfg_now[i].edge_sel) status[i] = s_q.lat[i];
            else                          status[i] = pin_s[i] ^ cfg_now[i].invert;
        end
    end

endmodule

// File: rtl/gpio_irq_sense.sv
module gpio_irq_sense #(
    parameter int NPIN        = 32,
    parameter int SYNC_STAGES = 2,
    parameter bit HAS_BOTH    = 1'b1
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NPIN-1:0] pin_in,
    input  logic [NPIN-1:0] cfg_irq_mode,
    input  logic [NPIN-1:0] cfg_invert,
    input  logic [NPIN-1:0] cfg_edge,
    input  logic [NPIN-1:0] cfg_both,
    input  logic [NPIN-1:0] irq_enable,
    input  logic [NPIN-1:0] clr_vec,
    output logic [NPIN-1:0] status,
    output logic            irq
);
    logic [NPIN-1:0] pin_sync;

    gis_sync #(.W(NPIN), .STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d_in  (pin_in),
        .d_out (pin_sync)
    );

    gis_sense #(.NPIN(NPIN), .HAS_BOTH(HAS_BOTH)) u_sense (
        .clk          (clk),
        .rst_n        (rst_n),
        .pin_s        (pin_sync),
        .cfg_irq_mode (cfg_irq_mode),
        .cfg_invert   (cfg_invert),
        .cfg_edge     (cfg_edge),
        .cfg_both     (cfg_both),
        .clr_vec      (clr_vec),
        .status       (status)
    );

    assign irq = |(status & irq_enable);

endmodule

// File: rtl/gpio_irq_sense_chk.sv
module gpio_irq_sense_chk #(
    parameter int NPIN = 32
) (
    input logic            clk,
    input logic            rst_n,
    input logic [NPIN-1:0] pin_sync,
    input logic [NPIN-1:0] cfg_irq_mode,
    input logic [NPIN-1:0] cfg_invert,
    input logic [NPIN-1:0] cfg_edge,
    input logic [NPIN-1:0] irq_enable,
    input logic [NPIN-1:0] clr_vec,
    input logic [NPIN-1:0] status,
    input logic            irq
);
    AST_IDLE_PIN_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        ((status & ~cfg_irq_mode) == '0)); // R3

    AST_LEVEL_TRACKS_PIN: assert property (@(posedge clk) disable iff (!rst_n)
        (((status ^ (pin_sync ^ cfg_invert)) & cfg_irq_mode & ~cfg_edge) == '0)); // R4

    AST_EDGE_LATCH_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((($past(status) & ~status) & $past(cfg_irq_mode & cfg_edge & ~clr_vec)
                   & cfg_irq_mode & cfg_edge) == '0)); // R8

    AST_IRQ_HAS_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> ((status & irq_enable) != '0)); // R11

    AST_SOURCE_RAISES_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
        ((status & irq_enable) != '0) |-> irq); // R11

endmodule

bind gpio_irq_sense gpio_irq_sense_chk #(.NPIN(NPIN)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .pin_sync     (pin_sync),
    .cfg_irq_mode (cfg_irq_mode),
    .cfg_invert   (cfg_invert),
    .cfg_edge     (cfg_edge),
    .irq_enable   (irq_enable),
    .clr_vec      (clr_vec),
    .status       (status),
    .irq          (irq)
);

// File: tb/gpio_irq_sense_bench.sv
module gpio_irq_sense_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] pin = '0, mode = '0, inv = '0, edg = '0, both = '0, clr = '0, en = '0;
    logic [31:0] st_a;
    logic        irq_a;
    logic [7:0]  st_b;
    logic        irq_b;
    int          checks = 0;
    int          fails  = 0;
    bit          done   = 1'b0;

    always #2.5 clk = ~clk;

    gpio_irq_sense #(.NPIN(32), .SYNC_STAGES(2), .HAS_BOTH(1'b1)) u_gpio_irq_sense (
        .clk(clk), .rst_n(rst_n), .pin_in(pin), .cfg_irq_mode(mode), .cfg_invert(inv),
        .cfg_edge(edg), .cfg_both(both), .irq_enable(en), .clr_vec(clr),
        .status(st_a), .irq(irq_a));

    gpio_irq_sense #(.NPIN(8), .SYNC_STAGES(2), .HAS_BOTH(1'b0)) u_gpio_irq_sense_nb (
        .clk(clk), .rst_n(rst_n), .pin_in(pin[7:0]), .cfg_irq_mode(mode[7:0]),
        .cfg_invert(inv[7:0]), .cfg_edge(edg[7:0]), .cfg_both(both[7:0]),
        .irq_enable(en[7:0]), .clr_vec(clr[7:0]), .status(st_b), .irq(irq_b));

    // ---- reference model built from the requirements ----
    logic [31:0] m_s1, m_s2, m_prev, m_mq, m_iq, m_eq, m_bq, a_lat, b_lat;

    function automatic logic [31:0] f_hit(input logic [31:0] cur, prv, chg, bth);
        logic [31:0] rise, fall, one;
        rise = cur & ~prv;
        fall = ~cur & prv;
        one  = (rise & ~inv) | (fall & inv);
        return mode & edg & ~chg & ((bth & (rise | fall)) | (~bth & one));
    endfunction

    function automatic logic [31:0] f_status(input logic [31:0] lat);
        return mode & ((edg & lat) | (~edg & (m_s2 ^ inv)));
    endfunction

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_s1 <= '0; m_s2 <= '0; m_prev <= '0; m_mq <= '0; m_iq <= '0;
            m_eq <= '0; m_bq <= '0; a_lat <= '0; b_lat <= '0;
        end else begin
            a_lat <= mode & edg & ((a_lat & ~clr) |
                     f_hit(m_s2, m_prev, (mode ^ m_mq) | (inv ^ m_iq) | (edg ^ m_eq) | (both ^ m_bq), both));
            b_lat <= 32'hFF & mode & edg & ((b_lat & ~clr) |
                     f_hit(m_s2, m_prev, (mode ^ m_mq) | (inv ^ m_iq) | (edg ^ m_eq), 32'h0));
            m_prev <= m_s2; m_s2 <= m_s1; m_s1 <= pin;
            m_mq <= mode; m_iq <= inv; m_eq <= edg; m_bq <= both;
        end
    end

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic step();
        logic [31:0] ea, eb;
        @(negedge clk);
        ea = f_status(a_lat);
        eb = f_status(b_lat) & 32'hFF;
        check("model R4 R5 R6 R8 R9 R10 status", st_a, ea);
        check("model R11 irq", {31'b0, irq_a}, {31'b0, |(ea & en)});
        check("model R7 R5 narrow status", {24'b0, st_b}, eb);
        check("model R11 narrow irq", {31'b0, irq_b}, {31'b0, |(eb & en & 32'hFF)});
    endtask

    task automatic steps(input int n);
        for (int k = 0; k < n; k++) step();
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog expired");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h5EED_0042));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        step();
        check("R1 status after reset", st_a, 32'h0);
        check("R1 irq after reset", {31'b0, irq_a}, 32'h0);

        // R2 + R4 level, active high on pin 0
        mode[0] = 1; en[0] = 1; pin[0] = 1;
        step();
        check("R2 level not yet through sync", {31'b0, st_a[0]}, 32'h0);
        step();
        check("R2 level through sync", {31'b0, st_a[0]}, 32'h1);
        check("R11 irq from enabled level", {31'b0, irq_a}, 32'h1);
        clr[0] = 1; step(); clr[0] = 0;
        check("R4 level ignores clear", {31'b0, st_a[0]}, 32'h1);
        inv[0] = 1; step();
        check("R4 active low sees high pin idle", {31'b0, st_a[0]}, 32'h0);
        inv[0] = 0; mode[0] = 0; step();
        check("R3 interrupt mode off", {31'b0, st_a[0]}, 32'h0);
        check("R11 irq low with no status", {31'b0, irq_a}, 32'h0);

        // R5 rising edge on pin 1
        mode[1] = 1; edg[1] = 1; steps(3);
        pin[1] = 1; steps(2);
        check("R2 edge not yet latched", {31'b0, st_a[1]}, 32'h0);
        step();
        check("R5 rising edge latched", {31'b0, st_a[1]}, 32'h1);
        pin[1] = 0; steps(4);
        check("R5 latch holds after pin returns", {31'b0, st_a[1]}, 32'h1);
        clr = 32'h1; step(); clr = 0;
        check("R8 zero bit leaves latch", {31'b0, st_a[1]}, 32'h1);
        clr = 32'h2; step(); clr = 0;
        check("R8 one bit clears latch", {31'b0, st_a[1]}, 32'h0);
        inv[1] = 1; steps(2);
        pin[1] = 1; steps(3);
        check("R5 falling mode ignores rise", {31'b0, st_a[1]}, 32'h0);
        pin[1] = 0; steps(3);
        check("R5 falling edge latched", {31'b0, st_a[1]}, 32'h1);

        // R6 / R7 both-edge on pin 2, invert set
        mode[2] = 1; edg[2] = 1; both[2] = 1; inv[2] = 1; steps(2);
        pin[2] = 1; steps(3);
        check("R6 both-edge catches rise", {31'b0, st_a[2]}, 32'h1);
        check("R7 narrow bank ignores both bit on rise", {31'b0, st_b[2]}, 32'h0);
        clr = 32'h4; step(); clr = 0;
        pin[2] = 0; steps(3);
        check("R6 both-edge catches fall", {31'b0, st_a[2]}, 32'h1);
        check("R7 narrow bank uses polarity", {31'b0, st_b[2]}, 32'h1);

        // R9 edge and clear collide on pin 3
        mode[3] = 1; edg[3] = 1; steps(2);
        pin[3] = 1; steps(2);
        clr = 32'h8; step(); clr = 0;
        check("R9 edge wins over clear", {31'b0, st_a[3]}, 32'h1);
        clr = 32'h8; step(); clr = 0;
        check("R8 later clear empties latch", {31'b0, st_a[3]}, 32'h0);

        // R10 config change suppresses edge on pin 5
        mode[5] = 1; edg[5] = 1; inv[5] = 1; steps(2);
        pin[5] = 1; steps(2);
        inv[5] = 0; step();
        check("R10 config change hides edge", {31'b0, st_a[5]}, 32'h0);
        // R10 leaving edge mode drops latch (pin 3)
        pin[3] = 0; mode[3] = 1; inv[3] = 1; steps(2);
        pin[3] = 1; steps(3);
        pin[3] = 0; steps(3);
        check("R10 precondition latch set", {31'b0, st_a[3]}, 32'h1);
        edg[3] = 0; step();
        edg[3] = 1; step();
        check("R10 latch emptied by mode exit", {31'b0, st_a[3]}, 32'h0);

        // random phase checked against the model
        for (int c = 0; c < 4000; c++) begin
            pin = pin ^ ($urandom & $urandom);
            clr = $urandom & $urandom & $urandom;
            if (($urandom % 8) == 0) begin
                int p;
                logic [3:0] r;
                p = $urandom % 32;
                r = 4'($urandom);
                mode[p] = r[0]; inv[p] = r[1]; edg[p] = r[2]; both[p] = r[3];
            end
            if (($urandom % 64) == 0) en = $urandom;
            step();
        end

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule